// File: doc/BRIEF.md
# Row-Batched Write-Back Sequencer

This block turns one DRAM row's worth of dirty bits into a burst of write-back requests. A job carries a row number, a dirty vector with one bit per line slot in that row, and an optional trigger offset. The job comes from one of two sources. One is the eviction of a dirty-tracking entry, which has no trigger. The other is the eviction of a dirty line that starts an aggressive row write-back; that line is the trigger.

The block captures the job in a one-entry buffer in the cycle it is offered, so the eviction that produced it finishes at once. The sequencer then works through the job in the background. It sends one request per set bit, lowest offset first, and all requests of a job go back to back to the same row so that every request after the first can hit the open row buffer.

After each accepted request the block sends a notification carrying the line address and a flag. The flag marks the trigger line, which must be invalidated. Every other line in the batch stays resident and is only marked clean. A done pulse closes each job.

Top module: `row_wb_seq`

## Requirements
- R1: After reset, job_ready_o is 1 and req_valid_o, cln_valid_o and done_o are 0.
- R2: A job is captured only in a cycle where job_valid_i and job_ready_o are both 1. job_ready_o is 0 from the cycle after capture until the cycle done_o is high. A job offered while job_ready_o is 0 has no effect on the requests of the running job.
- R3: A job with k set bits in job_dirty_i produces exactly k requests, one per set bit, in ascending offset order. Each request carries req_addr_o = {row, offset}, with the row in the upper ROW_W bits and the offset in the lower OFF_W bits.
- R4: While req_valid_o is 1 and req_ready_i is 0, req_valid_o stays 1 and req_addr_o stays unchanged in the next cycle.
- R5: The cycle after each request handshake (req_valid_o and req_ready_i both 1), cln_valid_o is 1 for one cycle and cln_addr_o equals the handshaken address. cln_valid_o is 0 in every other cycle.
- R6: cln_evict_o is 1 with a notification only when the job had job_trig_valid_i = 1 and the notified offset equals job_trig_off_i. Otherwise it is 0, so that line is only marked clean.
- R7: done_o is a single-cycle pulse, high in the cycle after the last request handshake of a job, together with the last notification.
- R8: A job whose dirty vector is all zeros issues no request and raises done_o in the second cycle after it is captured.
- R9: In the cycle done_o is high, job_ready_o is 1, so a new job can be captured at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| job_valid_i | input | 1 | Job offered |
| job_ready_o | output | 1 | Job buffer empty, job accepted this cycle if offered |
| job_row_i | input | ROW_W | DRAM row of the job |
| job_dirty_i | input | LINES | Dirty bit per line slot of the row |
| job_trig_valid_i | input | 1 | Job has a triggering evicted line |
| job_trig_off_i | input | OFF_W | Offset of the triggering line |
| req_valid_o | output | 1 | Write-back request valid |
| req_ready_i | input | 1 | Memory side takes the request |
| req_addr_o | output | ROW_W+OFF_W | Line address {row, offset} |
| cln_valid_o | output | 1 | Line-state update pulse |
| cln_addr_o | output | ROW_W+OFF_W | Line address of the update |
| cln_evict_o | output | 1 | 1: invalidate the line, 0: mark it clean |
| done_o | output | 1 | Job finished pulse |

## Verification
The bench sweeps every dirty vector of an 8-slot row. For each vector it runs three variants: full readiness with no trigger, stalling readiness with a trigger on an unset or arbitrary slot, and stalling readiness with the trigger on the lowest set slot. Each variant checks the request order, the address hold under backpressure, the notification timing and the evict flag. A design that scans from the wrong end, drops a bit when a request stalls, or drifts the address during a stall shows up as a wrong address in a given cycle. A design that flags every line as evicted, or that mishandles an empty vector by hanging or issuing a request, shows up as a wrong flag, a missing done pulse or an extra request. A second job offered in the middle of each run checks that the buffer cannot be overwritten.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  parameter int unsigned DEF_ROW_W = 8;
  parameter int unsigned DEF_LINES = 8;

  typedef enum logic {
    CLN_CLEAN = 1'b0,
    CLN_EVICT = 1'b1
  } cln_kind_e;
endpackage

// File: rtl/wbs_pick.sv
module wbs_pick #(
  parameter int unsigned LINES = 8,
  localparam int unsigned OFF_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] vec_i,
  output logic [LINES-1:0] onehot_o,
  output logic [OFF_W-1:0] idx_o
);
  logic [LINES-1:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 1; g < LINES; g++) begin : g_seen
    assign seen[g] = seen[g-1] | vec_i[g-1];
  end
  assign onehot_o = vec_i & ~seen;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (onehot_o[i]) idx_o = idx_o | OFF_W'(i);
    end
  end
endmodule

// File: rtl/wbs_job_buf.sv
module wbs_job_buf #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned LINES = 8,
  localparam int unsigned OFF_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [LINES-1:0] dirty_i,
  input  logic             tv_i,
  input  logic [OFF_W-1:0] toff_i,
  input  logic [LINES-1:0] clr_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [ROW_W-1:0] row_o,
  output logic [LINES-1:0] left_o,
  output logic             tv_o,
  output logic [OFF_W-1:0] toff_o
);
  logic [LINES-1:0] left_nx;

  assign left_nx = left_o & ~clr_i;
  assign fin_o   = busy_o && (left_nx == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      row_o  <= '0;
      left_o <= '0;
      tv_o   <= 1'b0;
      toff_o <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      row_o  <= row_i;
      left_o <= dirty_i;
      tv_o   <= tv_i;
      toff_o <= toff_i;
    end else if (busy_o) begin
      left_o <= left_nx;
      if (fin_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wbs_notify.sv
module wbs_notify #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  wbs_pkg::cln_kind_e kind_i,
  input  logic              fin_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              evict_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      evict_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= fire_i;
      done_o  <= fin_i;
      if (fire_i) begin
        addr_o  <= addr_i;
        evict_o <= (kind_i == wbs_pkg::CLN_EVICT);
      end else begin
        evict_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/row_wb_seq.sv
module row_wb_seq #(
  parameter int unsigned ROW_W = wbs_pkg::DEF_ROW_W,
  parameter int unsigned LINES = wbs_pkg::DEF_LINES,
  localparam int unsigned OFF_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned ADDR_W = ROW_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              job_valid_i,
  output logic              job_ready_o,
  input  logic [ROW_W-1:0]  job_row_i,
  input  logic [LINES-1:0]  job_dirty_i,
  input  logic              job_trig_valid_i,
  input  logic [OFF_W-1:0]  job_trig_off_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              cln_valid_o,
  output logic [ADDR_W-1:0] cln_addr_o,
  output logic              cln_evict_o,
  output logic              done_o
);
  logic             busy, fin, tv, fire;
  logic [ROW_W-1:0] row;
  logic [LINES-1:0] left, onehot, clr;
  logic [OFF_W-1:0] toff, idx;
  wbs_pkg::cln_kind_e kind;

  assign job_ready_o = !busy;
  assign req_valid_o = busy && (left != '0);
  assign fire        = req_valid_o && req_ready_i;
  assign clr         = fire ? onehot : '0;
  assign req_addr_o  = {row, idx};
  assign kind        = (tv && idx == toff) ? wbs_pkg::CLN_EVICT : wbs_pkg::CLN_CLEAN;

  wbs_job_buf #(.ROW_W(ROW_W), .LINES(LINES)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (job_valid_i && job_ready_o),
    .row_i   (job_row_i),
    .dirty_i (job_dirty_i),
    .tv_i    (job_trig_valid_i),
    .toff_i  (job_trig_off_i),
    .clr_i   (clr),
    .busy_o  (busy),
    .fin_o   (fin),
    .row_o   (row),
    .left_o  (left),
    .tv_o    (tv),
    .toff_o  (toff)
  );

  wbs_pick #(.LINES(LINES)) u_pick (
    .vec_i    (left),
    .onehot_o (onehot),
    .idx_o    (idx)
  );

  wbs_notify #(.ADDR_W(ADDR_W)) u_ntf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .addr_i  (req_addr_o),
    .kind_i  (kind),
    .fin_i   (fin),
    .valid_o (cln_valid_o),
    .addr_o  (cln_addr_o),
    .evict_o (cln_evict_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/row_wb_seq_chk.sv
module row_wb_seq_chk #(
  parameter int unsigned ROW_W = 8,
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              job_ready_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              cln_valid_o,
  input logic [ADDR_W-1:0] cln_addr_o,
  input logic              cln_evict_o,
  input logic              done_o
);
  a_r2_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !job_ready_o);

  a_r3_same_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(req_valid_o) && $past(rst_ni)) |->
      req_addr_o[ADDR_W-1 -: ROW_W] == $past(req_addr_o[ADDR_W-1 -: ROW_W]));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  a_r5_notify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> (cln_valid_o && cln_addr_o == $past(req_addr_o)));

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_o && req_ready_i) |=> !cln_valid_o);

  a_r6_evict_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cln_evict_o |-> cln_valid_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ready_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (job_ready_o && !req_valid_o));
endmodule

bind row_wb_seq row_wb_seq_chk #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .job_ready_o (job_ready_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .cln_valid_o (cln_valid_o),
  .cln_addr_o  (cln_addr_o),
  .cln_evict_o (cln_evict_o),
  .done_o      (done_o)
);

// File: tb/row_wb_seq_test.sv
module row_wb_seq_test;
  localparam int ROW_W = 8;
  localparam int LINES = 8;
  localparam int OFF_W = 3;
  localparam int ADDR_W = ROW_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_valid = 1'b0;
  logic job_ready;
  logic [ROW_W-1:0] job_row = '0;
  logic [LINES-1:0] job_dirty = '0;
  logic job_tv = 1'b0;
  logic [OFF_W-1:0] job_toff = '0;
  logic req_valid, req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr, cln_addr;
  logic cln_valid, cln_evict, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  row_wb_seq #(.ROW_W(ROW_W), .LINES(LINES)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .job_valid_i(job_valid), .job_ready_o(job_ready),
    .job_row_i(job_row), .job_dirty_i(job_dirty),
    .job_trig_valid_i(job_tv), .job_trig_off_i(job_toff),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .cln_valid_o(cln_valid), .cln_addr_o(cln_addr), .cln_evict_o(cln_evict),
    .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_job(input int mask, input int mode);
    int offs[LINES];
    int n = 0;
    int idx = 0;
    int c = 0;
    bit prev_fire = 0;
    int prev_off = 0;
    bit fin = 0;
    logic [ROW_W-1:0] row = ROW_W'((mask ^ 8'h5a) + mode * 37);
    bit tv = (mode != 0);
    int toff = (mode == 1) ? (mask % LINES) : 0;
    for (int i = 0; i < LINES; i++)
      if (mask[i]) begin offs[n] = i; n++; end
    if (mode == 2 && n > 0) toff = offs[0];

    @(negedge clk);
    chk("R2 ready when idle", job_ready, 1);
    job_valid = 1'b1; job_row = row; job_dirty = LINES'(mask);
    job_tv = tv; job_toff = OFF_W'(toff);
    while (!fin) begin
      @(negedge clk);
      // offer a conflicting job once while busy; it must be ignored
      if (c == 0) begin
        job_row = ~row; job_dirty = '1; job_tv = 1'b1; job_toff = '0;
      end else job_valid = 1'b0;
      chk("R5 notify valid", cln_valid, prev_fire);
      if (prev_fire) begin
        chk("R5 notify addr", cln_addr, {row, OFF_W'(prev_off)});
        chk("R6 evict flag", cln_evict, (tv && prev_off == toff));
      end
      if (n == 0) fin = (c == 1);
      else fin = prev_fire && (idx == n);
      chk(n == 0 ? "R8 empty done" : "R7 done timing", done, fin);
      chk(fin ? "R9 ready at done" : "R2 not ready while busy", job_ready, fin);
      if (fin) job_valid = 1'b0;
      chk("R3 request valid", req_valid, (idx < n));
      if (idx < n) chk("R3 R4 request addr", req_addr, {row, OFF_W'(offs[idx])});
      req_ready = (mode == 0) ? 1'b1 : (((c * 7 + mask) % 3) != 0);
      prev_fire = (idx < n) && req_ready;
      if (prev_fire) begin prev_off = offs[idx]; idx++; end
      c++;
    end
    @(negedge clk);
    chk("R7 done single pulse", done, 0);
    chk("R5 no notify after done", cln_valid, 0);
    req_ready = 1'b0;
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    chk("R1 ready", job_ready, 1);
    chk("R1 req", req_valid, 0);
    chk("R1 notify", cln_valid, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    for (int m = 0; m < (1 << LINES); m++)
      for (int md = 0; md < 3; md++)
        run_job(m, md);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule